// File: doc/BRIEF.md
# Contactless Transceive Sequencer

This block is the control state machine of a contactless reader front end. One exchange is a transmission followed by a reception. The sequencer walks through a fixed set of phases: idle, a wait before transmitting, the transmission, a guard wait, a wait for the first incoming data, and the reception. A loopback variant replaces the receive phases with two self-test states. The modulation, bit coding and data path are outside this block. They appear only as start, done and data-detect handshakes.

The current phase is exposed as a 3-bit code for software to read. The pre-transmit wait equals a programmed base count plus a phase trim in carrier cycles, so that the response timing of the exchange can be met. A 6-bit mask selects which phases raise an interrupt when they are entered. Each interrupt is a one-cycle pulse that also sets a sticky flag, and a write-1 pulse clears that flag. A multiple-receive option re-arms the receiver after every frame. A synchronous stop command aborts the exchange from any phase.

Top module: `trx_seq`

## Requirements
- R1: After reset, `state_o` is 0 (IDLE) and `irq_o`, `irq_sticky_o` and `rx_busy_o` are 0.
- R2: The state codes are 0 IDLE, 1 WaitTransmit, 2 Transmitting, 3 WaitReceive, 4 WaitForData, 5 Receiving, 6 WaitLoopBack, 7 LoopBack. A `start_i` pulse in IDLE moves to code 1 on the next edge. `start_i` has no effect in any other state.
- R3: WaitTransmit lasts exactly `tx_wait_i + trim_i + 1` cycles and then moves to Transmitting (2). Transmitting is held until `tx_done_i`.
- R4: `tx_done_i` in Transmitting moves to WaitReceive (3) when `loopback_i` is 0, and to WaitLoopBack (6) when `loopback_i` is 1.
- R5: WaitReceive and WaitLoopBack each last exactly `guard_i + 1` cycles. They then move to WaitForData (4) and LoopBack (7) respectively.
- R6: `data_det_i` in WaitForData moves to Receiving (5). `rx_busy_o` is 1 exactly while the state is 5 or 7.
- R7: `rx_done_i` in Receiving moves to IDLE when `multi_rx_i` is 0 and to WaitForData when it is 1. `rx_done_i` in LoopBack moves to IDLE.
- R8: `stop_i` forces IDLE on the next edge from any state and overrides every other input.
- R9: `irq_o` is high for exactly the first cycle of a newly entered state s < 6 when bit s of `irq_mask_i` (bit 0 IDLE … bit 5 Receiving) was set at the entering edge. It never fires for states 6 or 7, and it never fires when the state does not change.
- R10: `irq_sticky_o` is set by every `irq_o` event and cleared by an `irq_clr_i` pulse. When a set and a clear occur on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start an exchange (used in IDLE only) |
| stop_i | input | 1 | Synchronous abort to IDLE |
| loopback_i | input | 1 | Route through the loopback states after transmit |
| multi_rx_i | input | 1 | Re-arm the receiver after each frame |
| tx_done_i | input | 1 | Transmission finished |
| data_det_i | input | 1 | First incoming data seen |
| rx_done_i | input | 1 | Frame reception finished |
| tx_wait_i | input | WAIT_W | Base pre-transmit wait count |
| trim_i | input | TRIM_W | Phase trim in carrier cycles added to the wait |
| guard_i | input | GUARD_W | Guard count before waiting for data |
| irq_mask_i | input | 6 | Per-state interrupt-on-entry enables |
| irq_clr_i | input | 1 | Write-1 clear of the sticky flag |
| state_o | output | 3 | Current state code |
| rx_busy_o | output | 1 | Receive decoder active |
| irq_o | output | 1 | One-cycle interrupt pulse on entry |
| irq_sticky_o | output | 1 | Latched interrupt flag |

## Verification
The bench builds the block with WAIT_W = 8, GUARD_W = 4 and TRIM_W = 8. With these widths the largest pre-transmit wait, 511 cycles, and the largest guard, 16 cycles, fall inside a short run. Random sweeps of the wait, trim, guard, loopback, multiple-receive and mask settings can therefore reach the full-scale sum of wait and trim, and the zero-count waits at the other end. Directed cases cover the stop command in mid-wait and in the data wait, a start pulse outside IDLE, and a sticky clear that coincides with a new entry event.

// File: rtl/trx_pkg.sv
package trx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WTX   = 3'd1,
    ST_TX    = 3'd2,
    ST_WRX   = 3'd3,
    ST_WDATA = 3'd4,
    ST_RX    = 3'd5,
    ST_WLB   = 3'd6,
    ST_LB    = 3'd7
  } trx_state_e;

  localparam int IRQ_STATES = 6;
endpackage

// File: rtl/trx_timer.sv
module trx_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = run_i && (cnt_q == limit_i);
endmodule

// File: rtl/trx_next.sv
module trx_next
  import trx_pkg::*;
(
  input  trx_state_e state_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       loopback_i,
  input  logic       multi_rx_i,
  input  logic       tx_done_i,
  input  logic       data_det_i,
  input  logic       rx_done_i,
  input  logic       wait_hit_i,
  output trx_state_e next_o
);
  always_comb begin
    next_o = state_i;
    unique case (state_i)
      ST_IDLE:  if (start_i)    next_o = ST_WTX;
      ST_WTX:   if (wait_hit_i) next_o = ST_TX;
      ST_TX:    if (tx_done_i)  next_o = loopback_i ? ST_WLB : ST_WRX;
      ST_WRX:   if (wait_hit_i) next_o = ST_WDATA;
      ST_WDATA: if (data_det_i) next_o = ST_RX;
      ST_RX:    if (rx_done_i)  next_o = multi_rx_i ? ST_WDATA : ST_IDLE;
      ST_WLB:   if (wait_hit_i) next_o = ST_LB;
      ST_LB:    if (rx_done_i)  next_o = ST_IDLE;
      default:                  next_o = ST_IDLE;
    endcase
    if (stop_i) next_o = ST_IDLE;
  end
endmodule

// File: rtl/trx_irq.sv
module trx_irq
  import trx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enter_evt_i,
  input  logic                  clr_i,
  output logic                  irq_o,
  output logic                  sticky_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o    <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      irq_o    <= enter_evt_i;
      sticky_o <= enter_evt_i | (sticky_o & ~clr_i);
    end
  end
endmodule

// File: rtl/trx_seq.sv
module trx_seq
  import trx_pkg::*;
#(
  parameter int WAIT_W  = 16,
  parameter int GUARD_W = 8,
  parameter int TRIM_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  loopback_i,
  input  logic                  multi_rx_i,
  input  logic                  tx_done_i,
  input  logic                  data_det_i,
  input  logic                  rx_done_i,
  input  logic [WAIT_W-1:0]     tx_wait_i,
  input  logic [TRIM_W-1:0]     trim_i,
  input  logic [GUARD_W-1:0]    guard_i,
  input  logic [IRQ_STATES-1:0] irq_mask_i,
  input  logic                  irq_clr_i,
  output logic [2:0]            state_o,
  output logic                  rx_busy_o,
  output logic                  irq_o,
  output logic                  irq_sticky_o
);
  localparam int SUM_W = ((WAIT_W > TRIM_W) ? WAIT_W : TRIM_W) + 1;
  localparam int CNT_W = (SUM_W > GUARD_W) ? SUM_W : GUARD_W;

  // Pre-transmit limit: base wait plus phase trim (counter hits after limit+1 cycles)
  function automatic logic [CNT_W-1:0] tx_limit(input logic [WAIT_W-1:0] w,
                                                 input logic [TRIM_W-1:0] t);
    return CNT_W'(w) + CNT_W'(t);
  endfunction

  function automatic logic [CNT_W-1:0] guard_limit(input logic [GUARD_W-1:0] g);
    return CNT_W'(g);
  endfunction

  trx_state_e       state_q, nxt_state;
  logic             in_wait, state_chg, wait_hit, enter_evt;
  logic [CNT_W-1:0] wait_limit;
  logic [7:0]       mask_ext;

  assign in_wait    = (state_q == ST_WTX) || (state_q == ST_WRX) || (state_q == ST_WLB);
  assign wait_limit = (state_q == ST_WTX) ? tx_limit(tx_wait_i, trim_i) : guard_limit(guard_i);
  assign state_chg  = (nxt_state != state_q);
  assign mask_ext   = {{(8-IRQ_STATES){1'b0}}, irq_mask_i};
  assign enter_evt  = state_chg && mask_ext[nxt_state];

  trx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (in_wait),
    .restart_i (state_chg),
    .limit_i   (wait_limit),
    .hit_o     (wait_hit)
  );

  trx_next u_next (
    .state_i    (state_q),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .loopback_i (loopback_i),
    .multi_rx_i (multi_rx_i),
    .tx_done_i  (tx_done_i),
    .data_det_i (data_det_i),
    .rx_done_i  (rx_done_i),
    .wait_hit_i (wait_hit),
    .next_o     (nxt_state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= nxt_state;
  end

  trx_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_evt_i (enter_evt),
    .clr_i       (irq_clr_i),
    .irq_o       (irq_o),
    .sticky_o    (irq_sticky_o)
  );

  assign state_o   = state_q;
  assign rx_busy_o = (state_q == ST_RX) || (state_q == ST_LB);
endmodule

// File: rtl/trx_seq_chk.sv
module trx_seq_chk
  import trx_pkg::*;
#(
  parameter int WAIT_W  = 16,
  parameter int TRIM_W  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  stop_i,
  input logic                  tx_done_i,
  input logic                  data_det_i,
  input logic [WAIT_W-1:0]     tx_wait_i,
  input logic [TRIM_W-1:0]     trim_i,
  input logic [IRQ_STATES-1:0] irq_mask_i,
  input logic [2:0]            state_o,
  input logic [2:0]            nxt_state,
  input logic                  irq_o,
  input logic                  irq_sticky_o
);
  localparam int WC_W = ((WAIT_W > TRIM_W) ? WAIT_W : TRIM_W) + 2;

  logic [WC_W-1:0] wt_cnt;
  logic [7:0]      mask_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wt_cnt <= '0;
      mask_d <= '0;
    end else begin
      wt_cnt <= (state_o == ST_WTX) ? wt_cnt + 1'b1 : '0;
      mask_d <= {2'b00, irq_mask_i};
    end
  end

  a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (state_o == ST_IDLE));

  a_r2_enter_wtx: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_WTX && $past(state_o) != ST_WTX) |-> ($past(state_o) == ST_IDLE && $past(start_i)));

  a_r3_wait_len: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_WTX && nxt_state == ST_TX) |-> (wt_cnt == WC_W'(tx_wait_i) + WC_W'(trim_i)));

  a_r4_tx_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == ST_WRX || state_o == ST_WLB) && $past(state_o) != state_o) |-> ($past(state_o) == ST_TX && $past(tx_done_i)));

  a_r6_rx_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_RX && $past(state_o) == ST_WDATA) |-> $past(data_det_i));

  a_r9_irq_change: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (state_o != $past(state_o) && state_o < 3'd6));

  a_r9_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != $past(state_o) && state_o < 3'd6 && mask_d[state_o]) |-> irq_o);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_sticky_o);
endmodule

bind trx_seq trx_seq_chk #(.WAIT_W(WAIT_W), .TRIM_W(TRIM_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .tx_done_i    (tx_done_i),
  .data_det_i   (data_det_i),
  .tx_wait_i    (tx_wait_i),
  .trim_i       (trim_i),
  .irq_mask_i   (irq_mask_i),
  .state_o      (state_o),
  .nxt_state    (nxt_state),
  .irq_o        (irq_o),
  .irq_sticky_o (irq_sticky_o)
);

// File: tb/tb_trx_seq.sv
module tb_trx_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_W  = 8;
  localparam int GUARD_W = 4;
  localparam int TRIM_W  = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, loopback_i = 0, multi_rx_i = 0;
  logic tx_done_i = 0, data_det_i = 0, rx_done_i = 0, irq_clr_i = 0;
  logic [WAIT_W-1:0]  tx_wait_i = '0;
  logic [TRIM_W-1:0]  trim_i = '0;
  logic [GUARD_W-1:0] guard_i = '0;
  logic [5:0]         irq_mask_i = '0;
  logic [2:0]         state_o;
  logic rx_busy_o, irq_o, irq_sticky_o;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  trx_seq #(.WAIT_W(WAIT_W), .GUARD_W(GUARD_W), .TRIM_W(TRIM_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Expected durations, restated from the requirements
  function automatic int exp_wtx_cycles(int w, int t); return w + t + 1; endfunction
  function automatic int exp_guard_cycles(int g); return g + 1; endfunction
  function automatic bit exp_busy(int s); return (s == 5) || (s == 7); endfunction

  // Interrupt / sticky scoreboard
  logic       clr_seen = 0;
  logic [7:0] mask_seen = '0;
  int  prev_st = 0;
  bit  stk_m = 0;
  always @(posedge clk) begin
    clr_seen  <= irq_clr_i;
    mask_seen <= {2'b00, irq_mask_i};
    cycles    <= cycles + 1;
  end
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_st = 0; stk_m = 0;
    end else if (!done) begin
      bit e;
      e = (int'(state_o) != prev_st) && (state_o < 3'd6) && mask_seen[state_o];
      stk_m = e | (stk_m & ~clr_seen);
      chk(irq_o == e, "R9 irq pulse", irq_o, e);
      chk(irq_sticky_o == stk_m, "R10 sticky", irq_sticky_o, stk_m);
      chk(rx_busy_o == exp_busy(state_o), "R6 busy", rx_busy_o, exp_busy(state_o));
      prev_st = state_o;
    end
  end

  task automatic drv_pulse(ref logic sig);
    @(posedge clk); #1 sig = 1'b1;
    @(posedge clk); #1 sig = 1'b0;
  endtask

  task automatic expect_state(input int exp, input string tag);
    @(negedge clk);
    chk(int'(state_o) == exp, tag, state_o, exp);
  endtask

  // count negedges spent in state s, return with state observed != s
  task automatic count_in(input int s, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (int'(state_o) == s) n++;
      else break;
      if (n > 2000) break;
    end
  endtask

  task automatic exchange(input int w, input int t, input int g, input bit lb, input bit mr, input bit [5:0] m);
    int n;
    @(posedge clk); #1;
    tx_wait_i = w[WAIT_W-1:0]; trim_i = t[TRIM_W-1:0]; guard_i = g[GUARD_W-1:0];
    loopback_i = lb; multi_rx_i = mr; irq_mask_i = m;
    drv_pulse(start_i);
    count_in(1, n);
    chk(n == exp_wtx_cycles(w, t), "R3 wait length", n, exp_wtx_cycles(w, t));
    chk(int'(state_o) == 2, "R3 enter transmitting", state_o, 2);
    drv_pulse(tx_done_i);
    @(negedge clk);
    chk(int'(state_o) == (lb ? 6 : 3), "R4 post-tx state", state_o, lb ? 6 : 3);
    count_in(lb ? 6 : 3, n);
    chk(n + 1 == exp_guard_cycles(g), "R5 guard length", n + 1, exp_guard_cycles(g));
    chk(int'(state_o) == (lb ? 7 : 4), "R5 after guard", state_o, lb ? 7 : 4);
    if (!lb) begin
      drv_pulse(data_det_i);
      expect_state(5, "R6 data detect");
      drv_pulse(rx_done_i);
      expect_state(mr ? 4 : 0, "R7 rx end");
      if (mr) begin
        drv_pulse(data_det_i);
        expect_state(5, "R7 re-armed receive");
        drv_pulse(stop_i);
        expect_state(0, "R8 stop in receive");
      end
    end else begin
      drv_pulse(rx_done_i);
      expect_state(0, "R7 loopback end");
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(state_o == 3'd0, "R1 reset state", state_o, 0);
    chk(irq_o == 0 && irq_sticky_o == 0 && rx_busy_o == 0, "R1 reset outputs",
        {irq_o, irq_sticky_o, rx_busy_o}, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // directed: zero waits, full-scale waits, loopback, multi-receive
    exchange(0, 0, 0, 0, 0, 6'h3f);
    exchange(255, 255, 15, 0, 0, 6'h00);
    exchange(3, 2, 1, 1, 0, 6'h2a);
    exchange(1, 0, 2, 0, 1, 6'h15);

    // R2: start outside IDLE has no effect
    @(posedge clk); #1 tx_wait_i = 0; trim_i = 0; loopback_i = 0; irq_mask_i = 6'h02;
    drv_pulse(start_i);
    count_in(1, n);
    drv_pulse(start_i);
    expect_state(2, "R2 start ignored in transmitting");

    // R8: stop from transmitting and in mid-wait
    drv_pulse(stop_i);
    expect_state(0, "R8 stop in transmitting");
    @(posedge clk); #1 tx_wait_i = 8'd40;
    drv_pulse(start_i);
    repeat (5) @(negedge clk);
    chk(state_o == 3'd1, "R2 in wait transmit", state_o, 1);
    drv_pulse(stop_i);
    expect_state(0, "R8 stop in wait transmit");
    // stop in IDLE: no entry, no irq (scoreboard), stays 0
    irq_mask_i = 6'h3f;
    drv_pulse(stop_i);
    expect_state(0, "R8 stop in idle");

    // R10: clear, then clear colliding with a new entry
    drv_pulse(irq_clr_i);
    @(negedge clk);
    chk(irq_sticky_o == 0, "R10 cleared", irq_sticky_o, 0);
    @(posedge clk); #1 tx_wait_i = 8'd3; start_i = 1; irq_clr_i = 1;
    @(posedge clk); #1 start_i = 0; irq_clr_i = 0;
    @(negedge clk);
    chk(irq_sticky_o == 1, "R10 set wins over clear", irq_sticky_o, 1);
    drv_pulse(stop_i);
    expect_state(0, "R8 stop after collide");

    // random sweep
    for (int i = 0; i < 16; i++) begin
      exchange($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 15),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 6'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule